// File: doc/BRIEF.md
# Dual Program Counter Branch Resolver

This block is the fetch-side controller of a six-phase in-order pipeline. Each instruction runs through fetch, decode, source read, destination read, execute and writeback, one phase per clock. The block keeps two program counters. The primary counter follows the sequential path. The alternate counter captures the jump target, which comes from the source operand. A zero test on the destination operand is done before execute, so the address of the next fetch is known in time and a conditional jump never flushes the pipeline.

The primary counter advances by one in decode. The alternate counter loads the target in source read. In destination read, the resolver looks at destination bits 31:1 and bit 0 separately and picks a counter. In execute, the next fetch goes out from that counter. In writeback, a taken jump is committed by copying the alternate counter into the primary one. A taken call also produces a write of its return address. The ALU, the register file and all opcodes other than jumps belong to other blocks.

Top module: `dpc_branch_resolver`

## Requirements
- R1: While reset is asserted, the block shows phase 0 (fetch), fetch address 0, alternate-select low, fetch strobe low and return-write low. Reset sets the primary counter to 0 and selects it.
- R2: Phases run in the fixed order fetch=0, decode=1, source read=2, destination read=3, execute=4, writeback=5, one clock each, and the order wraps from 5 back to 0.
- R3: The primary counter advances by one when the decode phase ends and wraps from 511 to 0. The counters are 9 bits wide.
- R4: Jump-if-not-zero (op code 4) stays on the sequential path when the destination is zero. It takes the target for any other destination value, including values where only bit 0 or only the upper bits are set.
- R5: Jump-if-zero (op code 5) takes the target when the destination is zero. It stays sequential for any other destination value.
- R6: Decrement-and-jump-if-not-zero (op code 6) stays sequential only when the destination before the decrement is exactly 1. It takes the target for every other value, including 0.
- R7: Unconditional jump (op code 1), call (op code 2) and return (op code 3) take the target whenever their condition input is high.
- R8: An instruction whose condition input is low never takes the target. The no-operation code (op code 0) never takes it either.
- R9: The fetch strobe is high only during the execute phase. During execute, the fetch address is the target if the jump is taken and the incremented primary counter if it is not.
- R10: After writeback, the fetch address equals the primary counter. That counter holds the target after a taken jump and the incremented value after a jump that is not taken.
- R11: The return-write strobe is high during writeback only for a taken call. Its address output then carries the incremented primary counter, which is the address after the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_in | input | 3 | Jump op code, sampled when decode ends |
| cond_in | input | 1 | Condition-met flag, sampled when decode ends |
| target_in | input | 9 | Source-operand jump target, sampled when source read ends |
| dst_in | input | 32 | Destination operand, tested when destination read ends |
| phase_o | output | 3 | Current pipeline phase |
| fetch_en | output | 1 | Fetch strobe for the next instruction |
| fetch_addr | output | 9 | Address from the selected counter |
| alt_sel | output | 1 | High while the alternate counter is selected |
| ret_we | output | 1 | Return-address write strobe |
| ret_addr | output | 9 | Return address to write |

## Verification
The assertions watch four things on every cycle: the phase rotation, the single-step advance of the primary counter in decode, the hold of the fetch address when a taken jump is committed, and the limits on when the fetch and return-write strobes may be high. They also check that a false condition never reaches the alternate select. Which counter each op code picks for each destination value can only be shown by the bench's scenarios. The same goes for the exact target and return addresses, and for the split between bit 0 and bits 31:1 when values such as 1, 2, 3 and 0x80000000 are compared with zero.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;
  typedef enum logic [2:0] {
    PH_FETCH = 3'd0,
    PH_DEC   = 3'd1,
    PH_SRC   = 3'd2,
    PH_DST   = 3'd3,
    PH_EXEC  = 3'd4,
    PH_WB    = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_JNZ  = 3'd4,
    OP_JZ   = 3'd5,
    OP_DJNZ = 3'd6,
    OP_RSV  = 3'd7
  } jop_e;
endpackage

// File: rtl/dpc_phase_seq.sv
`timescale 1ns/1ps
module dpc_phase_seq
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);
  phase_e ph_q, ph_d;

  always_comb begin
    if (ph_q == PH_WB) ph_d = PH_FETCH;
    else               ph_d = phase_e'(ph_q + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_FETCH;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/dpc_zero_det.sv
`timescale 1ns/1ps
module dpc_zero_det #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  output logic              is_zero,
  output logic              is_one
);
  logic upper_clear;

  assign upper_clear = ~|value[DATA_W-1:1];
  assign is_zero     = upper_clear & ~value[0];
  assign is_one      = upper_clear &  value[0];
endmodule

// File: rtl/dpc_decide.sv
`timescale 1ns/1ps
module dpc_decide
  import dpc_pkg::*;
(
  input  jop_e op,
  input  logic cond,
  input  logic is_zero,
  input  logic is_one,
  output logic take
);
  always_comb begin
    take = 1'b0;
    if (cond) begin
      unique case (op)
        OP_JMP, OP_CALL, OP_RET: take = 1'b1;
        OP_JNZ:                  take = ~is_zero;
        OP_JZ:                   take = is_zero;
        OP_DJNZ:                 take = ~is_one;
        default:                 take = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dpc_pc_pair.sv
`timescale 1ns/1ps
module dpc_pc_pair
  import dpc_pkg::*;
#(
  parameter int PC_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  phase_e          phase,
  input  logic [PC_W-1:0] target,
  input  logic            take,
  output logic [PC_W-1:0] pc_a,
  output logic [PC_W-1:0] sel_addr,
  output logic            sel_b
);
  logic [PC_W-1:0] pa_q, pa_d, pb_q, pb_d;
  logic            sb_q, sb_d;
  logic            pa_en, pb_en, sb_en;

  always_comb begin
    pa_en = 1'b0;
    pb_en = 1'b0;
    sb_en = 1'b0;
    pa_d  = pa_q;
    pb_d  = pb_q;
    sb_d  = sb_q;
    unique case (phase)
      PH_DEC: begin
        pa_en = 1'b1;
        pa_d  = pa_q + 1'b1;
        sb_en = 1'b1;
        sb_d  = 1'b0;
      end
      PH_SRC: begin
        pb_en = 1'b1;
        pb_d  = target;
      end
      PH_DST: begin
        sb_en = 1'b1;
        sb_d  = take;
      end
      PH_WB: begin
        pa_en = sb_q;
        pa_d  = pb_q;
        sb_en = 1'b1;
        sb_d  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      pb_q <= '0;
      sb_q <= 1'b0;
    end else begin
      if (pa_en) pa_q <= pa_d;
      if (pb_en) pb_q <= pb_d;
      if (sb_en) sb_q <= sb_d;
    end
  end

  assign pc_a     = pa_q;
  assign sel_b    = sb_q;
  assign sel_addr = sb_q ? pb_q : pa_q;
endmodule

// File: rtl/dpc_branch_resolver.sv
`timescale 1ns/1ps
module dpc_branch_resolver
  import dpc_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_in,
  input  logic              cond_in,
  input  logic [PC_W-1:0]   target_in,
  input  logic [DATA_W-1:0] dst_in,
  output logic [2:0]        phase_o,
  output logic              fetch_en,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              alt_sel,
  output logic              ret_we,
  output logic [PC_W-1:0]   ret_addr
);
  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[SYNC_N-1];

  phase_e phase;
  jop_e   op_q, op_d;
  logic   cond_q, cond_d, ins_en;
  logic   is_zero, is_one, take;
  logic [PC_W-1:0] pc_a;

  dpc_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_s_n),
    .phase (phase)
  );

  always_comb begin
    ins_en = (phase == PH_DEC);
    op_d   = jop_e'(op_in);
    cond_d = cond_in;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      op_q   <= OP_NOP;
      cond_q <= 1'b0;
    end else if (ins_en) begin
      op_q   <= op_d;
      cond_q <= cond_d;
    end
  end

  dpc_zero_det #(.DATA_W(DATA_W)) u_zdet (
    .value   (dst_in),
    .is_zero (is_zero),
    .is_one  (is_one)
  );

  dpc_decide u_dec (
    .op      (op_q),
    .cond    (cond_q),
    .is_zero (is_zero),
    .is_one  (is_one),
    .take    (take)
  );

  dpc_pc_pair #(.PC_W(PC_W)) u_pcs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .phase    (phase),
    .target   (target_in),
    .take     (take),
    .pc_a     (pc_a),
    .sel_addr (fetch_addr),
    .sel_b    (alt_sel)
  );

  assign phase_o  = phase;
  assign fetch_en = (phase == PH_EXEC);
  assign ret_we   = (phase == PH_WB) && alt_sel && (op_q == OP_CALL);
  assign ret_addr = pc_a;
endmodule

// File: rtl/dpc_branch_resolver_checker.sv
`timescale 1ns/1ps
module dpc_branch_resolver_checker #(
  parameter int PC_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      phase_o,
  input logic            fetch_en,
  input logic [PC_W-1:0] fetch_addr,
  input logic            alt_sel,
  input logic            ret_we,
  input logic            cond_in
);
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 3'd5) |=> (phase_o == $past(phase_o) + 3'd1));

  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd5) |=> (phase_o == 3'd0));

  a_r3_decode_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1) |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1)));

  a_r8_false_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd2 && !$past(cond_in)) |-> ##2 !alt_sel);

  a_r9_fetch_exec: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> (phase_o == 3'd4));

  a_r10_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd5 && alt_sel) |=> (fetch_addr == $past(fetch_addr)) && !alt_sel);

  a_r11_ret_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we |-> (alt_sel && phase_o == 3'd5));
endmodule

bind dpc_branch_resolver dpc_branch_resolver_checker #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .phase_o    (phase_o),
  .fetch_en   (fetch_en),
  .fetch_addr (fetch_addr),
  .alt_sel    (alt_sel),
  .ret_we     (ret_we),
  .cond_in    (cond_in)
);

// File: tb/dpc_branch_resolver_bench.sv
`timescale 1ns/1ps
module dpc_branch_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_in = 3'd0;
  logic        cond_in = 1'b0;
  logic [8:0]  target_in = 9'd0;
  logic [31:0] dst_in = 32'd0;
  logic [2:0]  phase_o;
  logic        fetch_en, alt_sel, ret_we;
  logic [8:0]  fetch_addr, ret_addr;

  int errors = 0;
  int checks = 0;
  logic [8:0] pa = 9'd0;

  always #2 clk = ~clk;

  dpc_branch_resolver u_dpc_branch_resolver (
    .clk(clk), .rst_n(rst_n), .op_in(op_in), .cond_in(cond_in),
    .target_in(target_in), .dst_in(dst_in), .phase_o(phase_o),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr), .alt_sel(alt_sel),
    .ret_we(ret_we), .ret_addr(ret_addr)
  );

  // {op[2:0], cond, target[8:0], dst[31:0], expected take}
  localparam int NV = 16;
  localparam logic [45:0] VEC [NV] = '{
    {3'd4, 1'b1, 9'h040, 32'h0000_0000, 1'b0},  // R4 zero
    {3'd4, 1'b1, 9'h041, 32'h0000_0002, 1'b1},  // R4 upper bit
    {3'd4, 1'b1, 9'h042, 32'h8000_0000, 1'b1},  // R4 top bit
    {3'd4, 1'b1, 9'h043, 32'h0000_0001, 1'b1},  // R4 bit 0 only
    {3'd5, 1'b1, 9'h050, 32'h0000_0000, 1'b1},  // R5 zero
    {3'd5, 1'b1, 9'h051, 32'h0000_0001, 1'b0},  // R5 bit 0
    {3'd5, 1'b1, 9'h052, 32'h0000_0002, 1'b0},  // R5 upper
    {3'd6, 1'b1, 9'h060, 32'h0000_0001, 1'b0},  // R6 exactly one
    {3'd6, 1'b1, 9'h061, 32'h0000_0000, 1'b1},  // R6 zero
    {3'd6, 1'b1, 9'h062, 32'h0000_0003, 1'b1},  // R6 three
    {3'd6, 1'b1, 9'h063, 32'h0001_0001, 1'b1},  // R6 high plus bit 0
    {3'd1, 1'b1, 9'h1FF, 32'h0000_0000, 1'b1},  // R7 jump to top
    {3'd2, 1'b1, 9'h010, 32'h0000_0005, 1'b1},  // R7 call, R3 wrap, R11
    {3'd3, 1'b1, 9'h020, 32'h0000_0000, 1'b1},  // R7 return
    {3'd1, 1'b0, 9'h030, 32'h0000_0000, 1'b0},  // R8 false cond
    {3'd0, 1'b1, 9'h031, 32'h0000_0000, 1'b0}   // R8 nop
  };

  function automatic string req_of(input logic [2:0] op, input logic cond);
    if (!cond || op == 3'd0) return "R8";
    case (op)
      3'd4:    return "R4";
      3'd5:    return "R5";
      3'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge while the phase is fetch; returns at the next fetch phase.
  task automatic run_one(input logic [2:0] op, input logic cond, input logic [8:0] tgt,
                         input logic [31:0] dst, input logic take);
    logic [8:0] inc;
    logic [8:0] exp_fetch;
    inc = pa + 9'd1;
    exp_fetch = take ? tgt : inc;
    check("R2 fetch phase", {29'd0, phase_o}, 32'd0);
    op_in = op; cond_in = cond; target_in = tgt; dst_in = dst;
    @(negedge clk);
    check("R2 decode phase", {29'd0, phase_o}, 32'd1);
    check("R9 no fetch in decode", {31'd0, fetch_en}, 32'd0);
    @(negedge clk);
    check("R3 increment", {23'd0, fetch_addr}, {23'd0, inc});
    @(negedge clk);
    @(negedge clk);
    check("R9 fetch strobe", {31'd0, fetch_en}, 32'd1);
    check(req_of(op, cond), {23'd0, fetch_addr}, {23'd0, exp_fetch});
    @(negedge clk);
    check("R11 ret_we", {31'd0, ret_we}, {31'd0, (take && op == 3'd2)});
    if (take && op == 3'd2) check("R11 ret_addr", {23'd0, ret_addr}, {23'd0, inc});
    @(negedge clk);
    pa = exp_fetch;
    check("R10 commit", {23'd0, fetch_addr}, {23'd0, pa});
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 phase", {29'd0, phase_o}, 32'd0);
    check("R1 fetch_addr", {23'd0, fetch_addr}, 32'd0);
    check("R1 alt_sel", {31'd0, alt_sel}, 32'd0);
    check("R1 strobes", {30'd0, fetch_en, ret_we}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++)
      run_one(VEC[i][45:43], VEC[i][42], VEC[i][41:33], VEC[i][32:1], VEC[i][0]);
    // R3 wrap: walk primary counter across 511 -> 0 with sequential ops
    run_one(3'd1, 1'b1, 9'h1FE, 32'd0, 1'b1);
    run_one(3'd0, 1'b1, 9'h000, 32'd0, 1'b0);
    run_one(3'd0, 1'b1, 9'h000, 32'd0, 1'b0);
    check("R3 wrap to zero", {23'd0, fetch_addr}, 32'd0);
    // R5 with false condition must stay sequential even on zero
    run_one(3'd5, 1'b0, 9'h0AA, 32'd0, 1'b0);
    // R1 reset mid-instruction
    run_one(3'd1, 1'b1, 9'h123, 32'd0, 1'b1);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid reset phase", {29'd0, phase_o}, 32'd0);
    check("R1 mid reset addr", {23'd0, fetch_addr}, 32'd0);
    check("R1 mid reset sel", {30'd0, alt_sel, fetch_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pa = 9'd0;
    run_one(3'd4, 1'b1, 9'h077, 32'd9, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule